// File: doc/BRIEF.md
# Loadable Up/Down Counter with Carry

This block is a wide synchronous binary counter that counts up or down. Several of them can be chained through a carry input and a carry output. An active-high asynchronous clear empties the register at once. On the rising clock edge, a fixed priority order applies: preset to all ones, then synchronous clear, then parallel load, then a count that is gated by enable and carry-in. A direction input chooses between increment and decrement.

The counter is made of equal-width slices, each with its own register and control decoder. A build-time option selects how carries move between slices:

- **Ripple:** each slice's carry output feeds the next slice.
- **Lookahead:** every slice's carry input comes from a prefix AND of the terminal flags of the slices below it.

The carry output is purely combinational. It goes high when enable and carry-in are both high and the whole count sits at its terminal value for the current direction. A following counter can therefore take it as its own carry-in.

Top module: `udc_counter`

## Requirements
- R1: While `aclr` is high, `q` is 0 at once, with no clock edge needed. Preset, clear, load and counting on the same edges have no effect while it is held.
- R2: With `preset` high at a rising edge, `q` becomes all ones. Clear, load, enable and carry-in are ignored on that edge.
- R3: With `sclr` high and `preset` low at a rising edge, `q` becomes 0. Load and counting are ignored on that edge.
- R4: With `load` high and both `preset` and `sclr` low, `din` is captured on the rising edge. Enable, carry-in and direction have no effect on that edge.
- R5: With no higher control active and `en` or `cin` low, `q` holds its value across the edge.
- R6: With `en` and `cin` both high and no higher control active, the rising edge adds 1 to `q` when `up`=1 and subtracts 1 when `up`=0.
- R7: `cout` is combinational and equals `en & cin & T`. T is `q`==all ones when `up`=1, and `q`==0 when `up`=0.
- R8: Counting wraps modulo 2^WIDTH. Incrementing all ones gives 0, and decrementing 0 gives all ones.
- R9: Carries and borrows cross every slice boundary within the same edge, for example 0x000000FF+1 = 0x00000100 and 0x00FFFFFF+1 = 0x01000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all synchronous controls |
| aclr | input | 1 | Asynchronous clear, active high |
| preset | input | 1 | Synchronous set to all ones |
| sclr | input | 1 | Synchronous clear to zero |
| load | input | 1 | Synchronous parallel load of `din` |
| en | input | 1 | Count enable |
| cin | input | 1 | Carry input from a lower counter |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| cout | output | 1 | Combinational terminal-count carry output |

## Verification
The register result (`q`) is due one rising edge after its controls are applied. The bench drives controls on the falling edge, lets one rising edge pass, and compares `q` at the following falling edge. `cout` and the asynchronous clear take effect within the same cycle, so they are sampled 1 ns after the inputs change, with no edge in between. The table walk, the directed cases and a long random run with an in-bench model all follow this same drive/edge/sample rhythm. The random run uses loads biased toward the two terminal values so that wrap-around in both directions occurs often.

// File: rtl/udc_pkg.sv
package udc_pkg;

   typedef enum logic [2:0] {
      OP_HOLD   = 3'd0,
      OP_FILL   = 3'd1,
      OP_ZERO   = 3'd2,
      OP_LOAD   = 3'd3,
      OP_INC    = 3'd4,
      OP_DEC    = 3'd5
   } udc_op_e;

endpackage

// File: rtl/udc_op_decode.sv
module udc_op_decode
   import udc_pkg::*;
(
   input  logic    preset,
   input  logic    sclr,
   input  logic    load,
   input  logic    en,
   input  logic    cin,
   input  logic    up,
   output udc_op_e op
);

   always_comb begin
      if (preset)          op = OP_FILL;
      else if (sclr)       op = OP_ZERO;
      else if (load)       op = OP_LOAD;
      else if (en && cin)  op = up ? OP_INC : OP_DEC;
      else                 op = OP_HOLD;
   end

endmodule

// File: rtl/udc_slice.sv
module udc_slice
   import udc_pkg::*;
#(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         aclr,
   input  logic         preset,
   input  logic         sclr,
   input  logic         load,
   input  logic         en,
   input  logic         cin,
   input  logic         up,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         term,
   output logic         cout
);

   localparam logic [W-1:0] ONES = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("udc_slice: W must be at least 1");
   end

   udc_op_e      op;
   logic [W-1:0] nxt;

   udc_op_decode u_dec (
      .preset (preset),
      .sclr   (sclr),
      .load   (load),
      .en     (en),
      .cin    (cin),
      .up     (up),
      .op     (op)
   );

   always_comb begin
      unique case (op)
         OP_FILL: nxt = ONES;
         OP_ZERO: nxt = '0;
         OP_LOAD: nxt = din;
         OP_INC:  nxt = q + 1'b1;
         OP_DEC:  nxt = q - 1'b1;
         default: nxt = q;
      endcase
   end

   always_ff @(posedge clk or posedge aclr) begin
      if (aclr) q <= '0;
      else      q <= nxt;
   end

   assign term = up ? (q == ONES) : (q == '0);
   assign cout = en & cin & term;

   // R1: the register stays empty for as long as the clear is held
   p_aclr_empty_r1: assert property (@(posedge clk) aclr |-> q == '0);

   // R2: preset fills the slice regardless of lower controls
   p_preset_fill_r2: assert property (@(posedge clk) disable iff (aclr)
      preset |=> q == ONES);

   // R3: sync clear beats load and count
   p_sclr_zero_r3: assert property (@(posedge clk) disable iff (aclr)
      (!preset && sclr) |=> q == '0);

   // R4: load captures din, count inputs ignored
   p_load_take_r4: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && load) |=> q == $past(din));

   // R5: no count without both enable and carry-in
   p_hold_r5: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && !load && !(en && cin)) |=> $stable(q));

   // R6: one step per edge in the selected direction
   p_step_r6: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && !load && en && cin) |=>
         q == ($past(up) ? $past(q) + 1'b1 : $past(q) - 1'b1));

   // R7: carry out only when the count is qualified
   p_cout_qual_r7: assert property (@(posedge clk) disable iff (aclr)
      cout |-> (en && cin));

endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
   parameter int WIDTH     = 32,
   parameter int SLICE_W   = 8,
   parameter bit LOOKAHEAD = 1'b1
)(
   input  logic             clk,
   input  logic             aclr,
   input  logic             preset,
   input  logic             sclr,
   input  logic             load,
   input  logic             en,
   input  logic             cin,
   input  logic             up,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             cout
);

   localparam int NS = WIDTH / SLICE_W;
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   if (SLICE_W < 1 || WIDTH < SLICE_W || (WIDTH % SLICE_W) != 0) begin : g_bad_geom
      $error("udc_counter: WIDTH must be a positive multiple of SLICE_W");
   end

   logic [NS-1:0] term_v;
   logic [NS-1:0] cout_v;
   logic [NS-1:0] cin_v;
   logic [NS:0]   pre;

   assign pre[0] = cin;

   for (genvar k = 0; k < NS; k++) begin : g_slice
      if (LOOKAHEAD) begin : g_la
         assign pre[k+1] = pre[k] & term_v[k];
         assign cin_v[k] = pre[k];
      end else begin : g_rip
         assign pre[k+1] = cout_v[k];
         if (k == 0) begin : g_first
            assign cin_v[k] = cin;
         end else begin : g_next
            assign cin_v[k] = cout_v[k-1];
         end
      end

      udc_slice #(.W(SLICE_W)) u_slice (
         .clk    (clk),
         .aclr   (aclr),
         .preset (preset),
         .sclr   (sclr),
         .load   (load),
         .en     (en),
         .cin    (cin_v[k]),
         .up     (up),
         .din    (din[k*SLICE_W +: SLICE_W]),
         .q      (q[k*SLICE_W +: SLICE_W]),
         .term   (term_v[k]),
         .cout   (cout_v[k])
      );
   end

   if (LOOKAHEAD) begin : g_cout_la
      assign cout = en & pre[NS];
   end else begin : g_cout_rip
      assign cout = cout_v[NS-1];
   end

   // R7: chained carry equals whole-word terminal detection
   p_cout_word_r7: assert property (@(posedge clk) disable iff (aclr)
      cout == (en && cin && (up ? (q == ONES) : (q == '0))));

   // R8: wrap up from all ones
   p_wrap_up_r8: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && !load && en && cin && up && q == ONES) |=> q == '0);

   // R8: wrap down from zero
   p_wrap_dn_r8: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && !load && en && cin && !up && q == '0) |=> q == ONES);

   // R9: whole-word increment across slices
   p_span_r9: assert property (@(posedge clk) disable iff (aclr)
      (!preset && !sclr && !load && en && cin && up) |=> q == $past(q) + 1'b1);

endmodule

// File: tb/tb_udc_counter.sv
`timescale 1ns/1ps
module tb_udc_counter;

   localparam int W = 32;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic         clk = 1'b0;
   logic         aclr, preset, sclr, load, en, cin, up;
   logic [W-1:0] din;
   logic [W-1:0] q;
   logic         cout;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   udc_counter #(.WIDTH(W), .SLICE_W(8), .LOOKAHEAD(1'b1)) dut (
      .clk(clk), .aclr(aclr), .preset(preset), .sclr(sclr), .load(load),
      .en(en), .cin(cin), .up(up), .din(din), .q(q), .cout(cout)
   );

   typedef struct packed {
      logic         pr, sc, ld, e, c, u;
      logic [W-1:0] d;
      logic         xco;
      logic [W-1:0] xq;
   } vec_t;

   localparam int NV = 15;
   // fields: preset sclr load en cin up din | cout before edge, q after edge
   localparam vec_t TBL [NV] = '{
      '{0,0,0,1,1,0, 32'h0,        1'b1, 32'hFFFFFFFF},  // R8 down wrap, R7
      '{0,0,0,1,1,1, 32'h0,        1'b1, 32'h00000000},  // R8 up wrap, R7
      '{0,0,1,0,0,1, 32'h000000FF, 1'b0, 32'h000000FF},  // R4
      '{0,0,0,1,1,1, 32'h0,        1'b0, 32'h00000100},  // R9
      '{0,0,0,1,1,0, 32'h0,        1'b0, 32'h000000FF},  // R9 borrow
      '{0,0,0,0,1,1, 32'h0,        1'b0, 32'h000000FF},  // R5 en low
      '{0,0,0,1,0,1, 32'h0,        1'b0, 32'h000000FF},  // R5 cin low
      '{0,0,1,1,1,1, 32'h00FFFFFF, 1'b0, 32'h00FFFFFF},  // R4 count ignored
      '{0,0,0,1,1,1, 32'h0,        1'b0, 32'h01000000},  // R9
      '{1,1,1,1,1,1, 32'h0,        1'b0, 32'hFFFFFFFF},  // R2
      '{0,1,1,1,1,1, 32'h12345678, 1'b1, 32'h00000000},  // R3, R7
      '{0,0,1,1,1,1, 32'hFFFFFFFE, 1'b0, 32'hFFFFFFFE},  // R4
      '{0,0,0,1,1,1, 32'h0,        1'b0, 32'hFFFFFFFF},  // R6 up
      '{0,0,0,1,0,1, 32'h0,        1'b0, 32'hFFFFFFFF},  // R7 cin low, R5
      '{0,0,0,1,1,0, 32'h0,        1'b0, 32'hFFFFFFFE}   // R6 down
   };

   task automatic chk_q(input string req, input logic [W-1:0] exp);
      checks++;
      if (q !== exp) begin
         errors++;
         $display("FAIL %s: q=%h expected %h", req, q, exp);
      end
   endtask

   task automatic chk_co(input string req, input logic exp);
      checks++;
      if (cout !== exp) begin
         errors++;
         $display("FAIL %s: cout=%b expected %b", req, cout, exp);
      end
   endtask

   task automatic drive(input logic pr, sc, ld, e, c, u, input logic [W-1:0] d);
      preset = pr; sclr = sc; load = ld; en = e; cin = c; up = u; din = d;
   endtask

   function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
         input logic pr, sc, ld, e, c, u, input logic [W-1:0] d);
      if (pr) return ONES;
      if (sc) return '0;
      if (ld) return d;
      if (e && c) return u ? cur + 1 : cur - 1;
      return cur;
   endfunction

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] mq;
      aclr = 1'b1;
      drive(0,0,0,0,0,1,'0);
      repeat (3) @(negedge clk);
      chk_q("R1 reset", '0);
      aclr = 1'b0;
      #1 chk_co("R7 idle", 1'b0);

      // table walk, starting on a falling edge
      foreach (TBL[i]) begin
         drive(TBL[i].pr, TBL[i].sc, TBL[i].ld, TBL[i].e, TBL[i].c, TBL[i].u, TBL[i].d);
         #1 chk_co($sformatf("R7 row %0d", i), TBL[i].xco);
         @(posedge clk); @(negedge clk);
         chk_q($sformatf("R2-R9 row %0d", i), TBL[i].xq);
      end

      // R7 cout at all-zero in down direction follows en combinationally
      drive(0,0,1,0,0,0,32'h0);
      @(posedge clk); @(negedge clk);
      drive(0,0,0,0,1,0,'0);
      #1 chk_co("R7 en low at zero", 1'b0);
      en = 1'b1;
      #1 chk_co("R7 down terminal", 1'b1);
      up = 1'b1;
      #1 chk_co("R7 up not terminal", 1'b0);

      // R1 asynchronous clear between edges
      drive(0,0,1,0,0,1,32'hA5A5A5A5);
      @(posedge clk); @(negedge clk);
      chk_q("R4 load", 32'hA5A5A5A5);
      #1 aclr = 1'b1;
      #0.5 chk_q("R1 async", '0);
      drive(1,0,1,1,1,1,32'h5A5A5A5A);
      @(posedge clk); @(negedge clk);
      chk_q("R1 overrides preset", '0);
      aclr = 1'b0;
      drive(0,0,0,0,0,1,'0);

      // random run against the model
      mq = '0;
      for (int n = 0; n < 3000; n++) begin
         logic pr, sc, ld, e, c, u;
         logic [W-1:0] d;
         int sel;
         pr = ($urandom % 32) == 0;
         sc = ($urandom % 32) == 0;
         ld = ($urandom % 10) == 0;
         e  = ($urandom % 4) != 0;
         c  = ($urandom % 4) != 0;
         u  = ($urandom % 2) != 0;
         sel = $urandom % 5;
         case (sel)
            0: d = '0;
            1: d = ONES;
            2: d = 32'h1;
            3: d = ONES - 1;
            default: d = $urandom;
         endcase
         drive(pr, sc, ld, e, c, u, d);
         #1 chk_co("R7 random", e && c && (u ? (mq == ONES) : (mq == '0)));
         mq = model_next(mq, pr, sc, ld, e, c, u, d);
         @(posedge clk); @(negedge clk);
         chk_q("R6 R8 random", mq);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule